// File: doc/BRIEF.md
# TPM-cycle LPC target interface

This block is the target end of a Low Pin Count bus, claiming only locality-addressed TPM read and write cycles. Each rising clock edge it samples the 4-bit address/data lines and the active-low frame strobe. From these it picks out the start code, the cycle type and direction, a 16-bit address and, for writes, one data byte. When the host's turnaround is over, the block hands the decoded access to a back end and waits for its answer. It then drives SYNC, read data and its own turnaround back onto the bus through an output value and an output-enable pair.

The back end sees a request flag together with the address, the direction and the write byte. Each clock, the back end either accepts the access (and returns read data), rejects it, or gives no answer yet. The first request clock is a decision clock in which the bus stays undriven. A rejection in that clock ends the cycle with no SYNC at all, so the host master-aborts it. An access left unanswered is stretched with long-wait SYNC nibbles until it is accepted. The SYNC error code is never produced. Every other cycle type, including standard I/O, is ignored. The frame strobe going low cancels whatever is in progress and restarts decoding.

Top module: `lpc_tpm_target`

## Requirements
- R1: A cycle is claimed only when the nibble on the last low-frame clock is 4'b0101 and the next nibble has bits [3:2] = 2'b00, with bit 1 giving the direction (1 = write, 0 = read). Any other start code (such as 4'b0000 for standard I/O) or cycle-type nibble is ignored: the lines stay undriven and be_req stays low.
- R2: A claimed cycle carries four address nibbles, most significant first, then two data nibbles for a write (low nibble first), then two host turnaround clocks. be_req rises on the clock after the second turnaround clock, with be_addr, be_wr and be_wdata holding the decoded values.
- R3: In the first be_req clock the lines are undriven. If be_rej is high in that clock (it takes priority over be_ack), be_req drops and the cycle ends with no SYNC ever driven.
- R4: If the first be_req clock has neither response, the long-wait code 4'b0110 is driven from the next clock on and held until be_ack. be_rej is ignored once a long wait has been driven.
- R5: On the clock after be_ack is sampled, the block drives the ready code 4'b0000 and be_req falls.
- R6: For a read, the two clocks after the ready code carry be_rdata as sampled with be_ack: first bits [3:0], then bits [7:4]. Later changes on be_rdata have no effect.
- R7: After the ready code (write) or the second data nibble (read), the block drives 4'hF for one clock and then releases the lines.
- R8: The first nibble the block drives in a cycle is always a SYNC code, either 4'b0000 or 4'b0110, and never the error code 4'b1010.
- R9: A low frame strobe in any clock releases the lines and drops be_req on the next clock, and decoding restarts from that clock's nibble.
- R10: A synchronous active-high rst returns the block to idle, with lad_oe and be_req low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| lframe_n | input | 1 | Active-low frame strobe |
| lad_in | input | 4 | Sampled address/data lines |
| lad_out | output | 4 | Value driven onto the lines when enabled |
| lad_oe | output | 1 | Output enable for the lines |
| be_req | output | 1 | A decoded access awaits a back-end answer |
| be_wr | output | 1 | Direction of the pending access, 1 = write |
| be_addr | output | 16 | Address of the pending access |
| be_wdata | output | 8 | Write byte of the pending access |
| be_ack | input | 1 | Back end accepts or completes the access |
| be_rej | input | 1 | Back end refuses the access |
| be_rdata | input | 8 | Read byte, sampled with be_ack |

## Verification
Reads and writes are run through four answer patterns: accepted in the decision clock, stretched by several waits, stretched while be_rej is also raised, and refused. Together these separate the undriven decision clock, the long-wait loop, the ignored late refusal and the silent master-abort. Start codes and cycle types that must not be claimed show that the decoder ignores them. The frame strobe is also dropped during the address, during a wait and during read data, and a reset is applied during a wait. A normal cycle follows each of these to show that decoding recovers. Read bytes that contain the nibble 4'hA, and read data changed after the acceptance, show that data nibbles come from the captured byte and are not mistaken for SYNC codes.

// File: rtl/lpc_tpm_pkg.sv
package lpc_tpm_pkg;
  localparam logic [3:0] START_TPM  = 4'b0101;
  localparam logic [3:0] SYNC_READY = 4'b0000;
  localparam logic [3:0] SYNC_LWAIT = 4'b0110;
  localparam logic [3:0] SYNC_ERR   = 4'b1010;
  localparam logic [3:0] NIB_TAR    = 4'hF;

  typedef enum logic [2:0] {
    D_IDLE, D_CTYPE, D_ADDR, D_WDATA, D_TAR
  } dec_st_t;

  typedef enum logic [2:0] {
    R_IDLE, R_DECIDE, R_WAIT, R_SYNC, R_RDATA, R_TAR
  } rsp_st_t;
endpackage

// File: rtl/lpc_tpm_decode.sv
module lpc_tpm_decode
  import lpc_tpm_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int TAR_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  output logic              hdr_done,
  output logic              wr,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);
  localparam int ANIB  = ADDR_W / 4;
  localparam int DNIB  = DATA_W / 4;
  localparam int MAX_AD = (ANIB > DNIB) ? ANIB : DNIB;
  localparam int MAXN  = (MAX_AD > TAR_CLKS) ? MAX_AD : TAR_CLKS;
  localparam int CNT_W = $clog2(MAXN + 1);

  dec_st_t          st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= D_IDLE;
      cnt   <= '0;
      wr    <= 1'b0;
      addr  <= '0;
      wdata <= '0;
    end else if (!frame_n) begin
      // every low-frame clock re-evaluates the start nibble
      st  <= (lad_in == START_TPM) ? D_CTYPE : D_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        D_CTYPE: begin
          if (lad_in[3:2] == 2'b00) begin
            wr  <= lad_in[1];
            st  <= D_ADDR;
            cnt <= '0;
          end else begin
            st <= D_IDLE;
          end
        end
        D_ADDR: begin
          addr <= {addr[ADDR_W-5:0], lad_in};
          if (cnt == CNT_W'(ANIB - 1)) begin
            cnt <= '0;
            st  <= wr ? D_WDATA : D_TAR;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        D_WDATA: begin
          wdata <= {lad_in, wdata[DATA_W-1:4]};
          if (cnt == CNT_W'(DNIB - 1)) begin
            cnt <= '0;
            st  <= D_TAR;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        D_TAR: begin
          if (cnt == CNT_W'(TAR_CLKS - 1)) begin
            cnt <= '0;
            st  <= D_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: st <= D_IDLE;
      endcase
    end
  end

  assign hdr_done = frame_n && (st == D_TAR) && (cnt == CNT_W'(TAR_CLKS - 1));
endmodule

// File: rtl/lpc_tpm_resp.sv
module lpc_tpm_resp
  import lpc_tpm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic              hdr_done,
  input  logic              wr,
  input  logic              be_ack,
  input  logic              be_rej,
  input  logic [DATA_W-1:0] be_rdata,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic              be_req
);
  localparam int DNIB  = DATA_W / 4;
  localparam int CNT_W = $clog2(DNIB + 1);

  rsp_st_t           st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= R_IDLE;
      cnt     <= '0;
      rdata_q <= '0;
      lad_out <= NIB_TAR;
      lad_oe  <= 1'b0;
      be_req  <= 1'b0;
    end else if (!frame_n) begin
      st     <= R_IDLE;
      lad_oe <= 1'b0;
      be_req <= 1'b0;
    end else begin
      case (st)
        R_IDLE: begin
          if (hdr_done) begin
            st     <= R_DECIDE;
            be_req <= 1'b1;
          end
        end
        R_DECIDE: begin
          if (be_rej) begin
            st     <= R_IDLE;
            be_req <= 1'b0;
          end else if (be_ack) begin
            st      <= R_SYNC;
            lad_oe  <= 1'b1;
            lad_out <= SYNC_READY;
            be_req  <= 1'b0;
            rdata_q <= be_rdata;
          end else begin
            st      <= R_WAIT;
            lad_oe  <= 1'b1;
            lad_out <= SYNC_LWAIT;
          end
        end
        R_WAIT: begin
          if (be_ack) begin
            st      <= R_SYNC;
            lad_out <= SYNC_READY;
            be_req  <= 1'b0;
            rdata_q <= be_rdata;
          end
        end
        R_SYNC: begin
          if (!wr) begin
            st      <= R_RDATA;
            cnt     <= '0;
            lad_out <= rdata_q[3:0];
            rdata_q <= rdata_q >> 4;
          end else begin
            st      <= R_TAR;
            lad_out <= NIB_TAR;
          end
        end
        R_RDATA: begin
          if (cnt == CNT_W'(DNIB - 1)) begin
            st      <= R_TAR;
            lad_out <= NIB_TAR;
          end else begin
            cnt     <= cnt + CNT_W'(1);
            lad_out <= rdata_q[3:0];
            rdata_q <= rdata_q >> 4;
          end
        end
        R_TAR: begin
          st     <= R_IDLE;
          lad_oe <= 1'b0;
        end
        default: st <= R_IDLE;
      endcase
    end
  end

  AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(lad_oe) |-> (lad_out == SYNC_READY || lad_out == SYNC_LWAIT)); // R8
  AST_NO_SYNC_ERR: assert property (@(posedge clk) disable iff (rst)
    $rose(lad_oe) |-> lad_out != SYNC_ERR); // R8
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !frame_n |=> (!lad_oe && !be_req)); // R9
  AST_DECIDE_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
    $rose(be_req) |-> !lad_oe); // R3
  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (be_req && !lad_oe && be_rej && frame_n) |=> (!lad_oe && !be_req)); // R3
  AST_WAIT_CODE: assert property (@(posedge clk) disable iff (rst)
    (be_req && lad_oe) |-> lad_out == SYNC_LWAIT); // R4
  AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (be_req && be_ack && !be_rej && frame_n) |=> (lad_oe && lad_out == SYNC_READY && !be_req)); // R5
endmodule

// File: rtl/lpc_tpm_target.sv
module lpc_tpm_target
  import lpc_tpm_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int TAR_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lframe_n,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic              be_req,
  output logic              be_wr,
  output logic [ADDR_W-1:0] be_addr,
  output logic [DATA_W-1:0] be_wdata,
  input  logic              be_ack,
  input  logic              be_rej,
  input  logic [DATA_W-1:0] be_rdata
);
  logic hdr_done;

  lpc_tpm_decode #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TAR_CLKS (TAR_CLKS)
  ) u_decode (
    .clk      (clk),
    .rst      (rst),
    .frame_n  (lframe_n),
    .lad_in   (lad_in),
    .hdr_done (hdr_done),
    .wr       (be_wr),
    .addr     (be_addr),
    .wdata    (be_wdata)
  );

  lpc_tpm_resp #(
    .DATA_W (DATA_W)
  ) u_resp (
    .clk      (clk),
    .rst      (rst),
    .frame_n  (lframe_n),
    .hdr_done (hdr_done),
    .wr       (be_wr),
    .be_ack   (be_ack),
    .be_rej   (be_rej),
    .be_rdata (be_rdata),
    .lad_out  (lad_out),
    .lad_oe   (lad_oe),
    .be_req   (be_req)
  );
endmodule

// File: tb/tb_lpc_tpm_target.sv
`timescale 1ns/1ps
module tb_lpc_tpm_target;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fr_n = 1'b1;
  logic [3:0]  lad_i = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic        be_req, be_wr;
  logic [15:0] be_addr;
  logic [7:0]  be_wdata;
  logic        ack = 1'b0, rej = 1'b0;
  logic [7:0]  rdata = 8'h00;

  int  checks = 0;
  int  fails  = 0;
  int  n_step = 0;
  int  abort_at = -1;
  bit  aborted = 1'b0;
  bit  abort_rst = 1'b0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  lpc_tpm_target dut (
    .clk(clk), .rst(rst), .lframe_n(fr_n), .lad_in(lad_i),
    .lad_out(lad_out), .lad_oe(lad_oe), .be_req(be_req), .be_wr(be_wr),
    .be_addr(be_addr), .be_wdata(be_wdata), .be_ack(ack), .be_rej(rej),
    .be_rdata(rdata)
  );

  // One clock of the reference model: drive, let one edge pass, compare.
  task automatic st(input bit f, input logic [3:0] l, input bit a, input bit r,
                    input bit eoe, input logic [3:0] eout, input bit ereq,
                    input string tag);
    if (aborted) return;
    if (n_step == abort_at) begin
      if (abort_rst) begin rst = 1'b1; f = 1'b1; tag = "R10"; end
      else begin f = 1'b0; tag = "R9"; end
      l = 4'h0; a = 1'b0; r = 1'b0; eoe = 1'b0; ereq = 1'b0;
      aborted = 1'b1;
    end
    n_step++;
    fr_n = f; lad_i = l; ack = a; rej = r;
    @(posedge clk); #1;
    checks++;
    if (lad_oe !== eoe || (eoe && lad_out !== eout) || be_req !== ereq) begin
      fails++;
      $display("FAIL %s: oe/out/req = %b/%h/%b, expected %b/%h/%b",
               tag, lad_oe, lad_out, be_req, eoe, eout, ereq);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    rst = 1'b0; aborted = 1'b0; abort_at = -1; abort_rst = 1'b0; n_step = 0;
    for (int i = 0; i < n; i++) st(1, 4'hF, 0, 0, 0, 4'h0, 0, "R1");
  endtask

  task automatic tpm_cycle(input logic [3:0] sc, input logic [3:0] ct,
                           input logic [15:0] ad, input logic [7:0] wd,
                           input int waits, input bit reject, input bit late_rej,
                           input bit both, input logic [7:0] rd, input int ab);
    bit wr = ct[1];
    bit claimed = (sc == 4'b0101) && (ct[3:2] == 2'b00);
    string t = claimed ? "R2" : "R1";
    n_step = 0; abort_at = ab; aborted = 1'b0; rdata = rd;
    st(0, sc, 0, 0, 0, 4'h0, 0, t);
    st(1, ct, 0, 0, 0, 4'h0, 0, t);
    for (int i = 0; i < 4; i++) st(1, ad[15-4*i -: 4], 0, 0, 0, 4'h0, 0, t);
    if (wr) begin
      st(1, wd[3:0], 0, 0, 0, 4'h0, 0, t);
      st(1, wd[7:4], 0, 0, 0, 4'h0, 0, t);
    end
    st(1, 4'hF, 0, 0, 0, 4'h0, 0, t);
    st(1, 4'hF, 0, 0, 0, 4'h0, claimed, t);
    if (!claimed || aborted) return;
    checks++;
    if (be_addr !== ad || be_wr !== wr || (wr && be_wdata !== wd)) begin
      fails++;
      $display("FAIL R2: addr/wr/wdata = %h/%b/%h, expected %h/%b/%h",
               be_addr, be_wr, be_wdata, ad, wr, wd);
    end
    if (reject) begin
      st(1, 4'hF, both, 1, 0, 4'h0, 0, "R3");
      return;
    end
    if (waits == 0) begin
      st(1, 4'hF, 1, 0, 1, 4'h0, 0, "R5");
    end else begin
      st(1, 4'hF, 0, 0, 1, 4'h6, 1, "R4");
      for (int w = 1; w <= waits; w++) begin
        if (w == waits) st(1, 4'hF, 1, 0, 1, 4'h0, 0, "R5");
        else            st(1, 4'hF, 0, late_rej, 1, 4'h6, 1, "R4");
      end
    end
    rdata = ~rd;  // captured byte must be used from here on
    if (!wr) begin
      st(1, 4'hF, 0, 0, 1, rd[3:0], 0, "R6");
      st(1, 4'hF, 0, 0, 1, rd[7:4], 0, "R6");
    end
    st(1, 4'hF, 0, 0, 1, 4'hF, 0, "R7");
    st(1, 4'hF, 0, 0, 0, 4'h0, 0, "R7");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R10 reset state
    if (lad_oe !== 1'b0 || be_req !== 1'b0) begin
      fails++;
      $display("FAIL R10: oe/req = %b/%b, expected 0/0", lad_oe, be_req);
    end
    idle(2);
    // R2 R5 R7: write accepted in decision clock
    tpm_cycle(4'h5, 4'h2, 16'hD4A3, 8'h5C, 0, 0, 0, 0, 8'h00, -1); idle(2);
    // R6 R8: read accepted at once, data nibbles include 4'hA
    tpm_cycle(4'h5, 4'h0, 16'h0F18, 8'h00, 0, 0, 0, 0, 8'hA7, -1); idle(2);
    // R4: read stretched, late rejection ignored
    tpm_cycle(4'h5, 4'h0, 16'h1234, 8'h00, 3, 0, 1, 0, 8'h3A, -1); idle(2);
    // R4: write stretched
    tpm_cycle(4'h5, 4'h3, 16'hBEEF, 8'hC6, 2, 0, 0, 0, 8'h00, -1); idle(2);
    // R3: write refused, read refused with ack also high
    tpm_cycle(4'h5, 4'h2, 16'h0024, 8'h99, 0, 1, 0, 0, 8'h00, -1); idle(2);
    tpm_cycle(4'h5, 4'h0, 16'h0030, 8'h00, 0, 1, 0, 1, 8'h55, -1); idle(2);
    // R1: standard I/O start, memory and DMA cycle types
    tpm_cycle(4'h0, 4'h0, 16'h0080, 8'h00, 0, 0, 0, 0, 8'h11, -1); idle(2);
    tpm_cycle(4'h0, 4'h2, 16'h0080, 8'h42, 0, 0, 0, 0, 8'h11, -1); idle(2);
    tpm_cycle(4'h5, 4'h4, 16'h0F00, 8'h00, 0, 0, 0, 0, 8'h11, -1); idle(2);
    tpm_cycle(4'h5, 4'h8, 16'h0F00, 8'h00, 0, 0, 0, 0, 8'h11, -1); idle(2);
    // R9: abort in address, in wait, in read data; each followed by a good cycle
    tpm_cycle(4'h5, 4'h0, 16'h4321, 8'h00, 0, 0, 0, 0, 8'h66, 3); idle(1);
    tpm_cycle(4'h5, 4'h0, 16'h4322, 8'h00, 0, 0, 0, 0, 8'h67, -1); idle(1);
    tpm_cycle(4'h5, 4'h0, 16'h5000, 8'h00, 4, 0, 0, 0, 8'h12, 10); idle(1);
    tpm_cycle(4'h5, 4'h2, 16'h5001, 8'h3C, 1, 0, 0, 0, 8'h00, -1); idle(1);
    tpm_cycle(4'h5, 4'h0, 16'h6000, 8'h00, 0, 0, 0, 0, 8'hE1, 10); idle(1);
    tpm_cycle(4'h5, 4'h0, 16'h6001, 8'h00, 0, 0, 0, 0, 8'h2D, -1); idle(2);
    // R10: reset during a wait
    abort_rst = 1'b1;
    tpm_cycle(4'h5, 4'h0, 16'h7000, 8'h00, 5, 0, 0, 0, 8'h44, 10); idle(2);
    tpm_cycle(4'h5, 4'h2, 16'h7001, 8'h81, 0, 0, 0, 0, 8'h00, -1); idle(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule